// File: doc/BRIEF.md
# Clocked Serial Shift Port with Automatic Wait

This block moves bytes between a processor register interface and a three-wire synchronous serial link. It has a clock line, a data-out line and a data-in line. Each byte is sent least significant bit first. The outgoing bit changes when the serial clock falls, and the incoming bit is sampled when the serial clock rises. A three-bit clock-select field picks the clock source. Seven of its codes select an internally divided clock, which the block drives onto the clock pin. The eighth code selects a clock that an external master drives into the block. That external clock is synchronised into the system clock domain before the block looks for edges.

When the block generates the clock, it never lets software fall behind the link. At each byte boundary it checks the enabled directions. The next byte starts only if every enabled direction is ready: a transmit byte must be waiting, and the last received byte must have been read. Otherwise the clock rests high until the missing bus access happens. A byte written while a transfer is running is held in the buffer. It is sent straight after the current byte, with no extra gap.

Register map (two-bit address): 0 = control, 1 = data (a write fills the transmit buffer, a read returns the receive buffer), 2 = status. Address 3 reads as zero.

Top module: `serial_shift_port`

## Requirements
- R1: After reset the clock output is high and the clock pin is driven (select code 0). The status register reads 0x02: transmit buffer empty, not busy, nothing received. The end-of-byte pulse is low.
- R2: With select code c from 0 to 6, the clock pin is driven and each clock phase lasts 2^(c+2) system clock cycles. A full clock period is therefore 2^(c+3) cycles.
- R3: A byte is shifted least significant bit first. The data-out line changes on the falling clock edge, and the data-in line is sampled on the rising edge. After eight clock periods the received byte can be read from address 1.
- R4: Whenever no byte is in progress, the clock output is high.
- R5: With transmit enabled (control bit 3) and internal clock, a byte starts only when the transmit buffer is full. After a data write, the first falling edge comes within one clock phase plus two cycles.
- R6: With receive enabled (control bit 4) and internal clock, no byte starts while the receive buffer is full. Reading address 1 clears it, and the next byte then starts within one clock phase plus two cycles.
- R7: A data write during a transfer is queued. The next byte follows after exactly one high phase. Status bit 1 (transmit empty) is set when the buffer is loaded into the shifter, and is cleared by the write.
- R8: Select code 7 releases the clock pin (output enable low) and keeps the generated clock high. Bytes are then shifted on the edges of the external clock after a two-flop synchroniser. Each phase of that clock must last more than 8 cycles. There is no automatic wait in this mode.
- R9: At the end of each byte the block raises a one-cycle pulse. It also sets status bit 0 (busy) during the byte, and sets status bit 2 (receive full) when receive is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a data read clears receive-full |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the clock pin (low in external mode) |
| sck_i | input | 1 | Serial clock from the pin in external mode |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| byte_done | output | 1 | One-cycle pulse after each completed byte |

## Verification
A wrong prescaler count shows as a clock phase of the wrong length on the very first falling edge. A wrong bit counter or a wrong shift direction corrupts the byte that is read back after eight clock periods. If the wait condition is wrong, the clock pin toggles while the status register shows a pending buffer; the bench watches for that over a long idle window. If the wait condition is wrong the other way, the restart arrives late, which the bench sees as a start delay longer than one phase. A missing queue shows up between back-to-back bytes: either the gap before the second byte is not exactly one phase, or the second byte is wrong.

// File: rtl/sio_pkg.sv
// Shared constants and the control register layout for the serial shift port.
package sio_pkg;
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] EXT_CODE = '1;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    // Control register: bit 4 receive enable, bit 3 transmit enable, bits 2:0 clock select
    typedef struct packed {
        logic              rx_en;
        logic              tx_en;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sio_clkgen.sv
// Internal serial clock generator.
// Counts system clocks and toggles the serial clock every 2^(BASE_EXP+code) cycles.
// While run is low, the counter is cleared and the clock rests high, so a restart
// always begins with a full high phase. Assumes code 7 is never used with run high.
module sio_clkgen #(
    parameter int CODE_W   = 3,
    parameter int BASE_EXP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              fall_ev,
    output logic              rise_ev,
    output logic              sck_lvl
);
    localparam int CNT_W = BASE_EXP + (1 << CODE_W) - 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             tick;

    // Terminal count for one phase: a mask of (BASE_EXP + code) low ones
    assign limit   = ~({CNT_W{1'b1}} << (BASE_EXP + int'(code)));
    assign tick    = run && (cnt == limit);
    assign fall_ev = tick && sck_lvl;
    assign rise_ev = tick && !sck_lvl;

    // Phase counter and clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            sck_lvl <= 1'b1;
        end else if (!run) begin
            cnt     <= '0;
            sck_lvl <= 1'b1;
        end else if (tick) begin
            cnt     <= '0;
            sck_lvl <= ~sck_lvl;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sio_ext_sync.sv
// Brings an external serial clock into the system clock domain.
// Two flops resynchronise it and a third flop gives edge detection.
// The idle level is high. Assumes each input phase lasts well over three cycles.
module sio_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic fall_ev,
    output logic rise_ev
);
    logic [2:0] sync_q;

    assign fall_ev = sync_q[2] && !sync_q[1];
    assign rise_ev = !sync_q[2] && sync_q[1];

    // Synchroniser and edge history shift
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[1:0], sck_i};
    end
endmodule

// File: rtl/sio_shift_engine.sv
// Byte framing and shifting.
// A falling event outside a byte loads the transmit buffer and presents bit 0.
// Later falling events present the next bits. Each rising event samples the input.
// The eighth rising event completes the byte. Assumes fall and rise events never coincide.
module sio_shift_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              si,
    output logic              so,
    output logic              in_byte,
    output logic              load_tx,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] txsh;
    logic [DATA_W-2:0] rxsh;
    logic [BIT_W-1:0]  bit_cnt;

    assign load_tx = fall_ev && !in_byte;
    assign done    = rise_ev && in_byte && (bit_cnt == LAST);
    assign rx_word = {si, rxsh};

    // Shift registers, bit counter and byte-in-progress flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txsh    <= '0;
            rxsh    <= '0;
            bit_cnt <= '0;
            in_byte <= 1'b0;
            so      <= 1'b1;
        end else begin
            if (load_tx) begin
                txsh    <= tx_data >> 1;
                so      <= tx_data[0];
                in_byte <= 1'b1;
                bit_cnt <= '0;
            end else if (fall_ev && in_byte) begin
                so      <= txsh[0];
                txsh    <= txsh >> 1;
            end
            if (rise_ev && in_byte) begin
                rxsh <= rx_word[DATA_W-1:1];
                if (bit_cnt == LAST) in_byte <= 1'b0;
                else                 bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_regs.sv
// Processor-side registers: control, transmit and receive buffers, status and read mux.
// A data write has priority over the shifter's load when both land on the same edge.
// Likewise, a byte completion has priority over a data read clearing receive-full.
module sio_regs #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            addr,
    input  logic                  ctrl_wr,
    input  logic                  data_wr,
    input  logic                  data_rd,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  load_tx,
    input  logic                  done,
    input  logic [DATA_W-1:0]     rx_word,
    input  logic                  busy,
    output sio_pkg::ctrl_t        ctrl_q,
    output logic [DATA_W-1:0]     tx_buf,
    output logic                  tx_full,
    output logic                  rx_full,
    output logic                  byte_done,
    output logic [DATA_W-1:0]     rdata
);
    import sio_pkg::*;

    logic [DATA_W-1:0] rx_buf;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Transmit buffer and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (data_wr) begin
            tx_buf  <= wdata;
            tx_full <= 1'b1;
        end else if (load_tx) begin
            tx_full <= 1'b0;
        end
    end

    // Receive buffer, its full flag and the end-of-byte pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            rx_full   <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= done;
            if (done && ctrl_q.rx_en) begin
                rx_buf  <= rx_word;
                rx_full <= 1'b1;
            end else if (data_rd) begin
                rx_full <= 1'b0;
            end
        end
    end

    // Read data mux
    always_comb begin
        case (addr)
            A_CTRL:  rdata = DATA_W'(ctrl_q);
            A_DATA:  rdata = rx_buf;
            A_STAT:  rdata = DATA_W'({rx_full, !tx_full, busy});
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/serial_shift_port.sv
// Top level of the clocked serial shift port.
// The top selects between the internal generator and the synchronised external clock.
// It also evaluates the automatic-wait condition at byte boundaries.
// Assumes the control register is changed only while no byte is in progress.
module serial_shift_port #(
    parameter int DATA_W   = 8,
    parameter int BASE_EXP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              so,
    input  logic              si,
    output logic              byte_done
);
    import sio_pkg::*;

    ctrl_t             ctrl_q;
    logic              ctrl_wr, data_wr, data_rd;
    logic              ext_mode, tx_en, rx_en, enabled, go, run;
    logic              tx_full, rx_full, in_byte, load_tx, done;
    logic              int_fall, int_rise, ext_fall, ext_rise, fall_ev, rise_ev;
    logic [DATA_W-1:0] tx_buf, rx_word;

    assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    assign data_wr  = bus_wr && (bus_addr == A_DATA);
    assign data_rd  = bus_rd && (bus_addr == A_DATA);

    assign ext_mode = (ctrl_q.code == EXT_CODE);
    assign tx_en    = ctrl_q.tx_en;
    assign rx_en    = ctrl_q.rx_en;
    assign enabled  = tx_en || rx_en;
    // Next byte permitted only when every enabled direction has been serviced
    assign go       = enabled && (!tx_en || tx_full) && (!rx_en || !rx_full);
    assign run      = !ext_mode && (in_byte || go);

    assign fall_ev  = ext_mode ? (enabled && ext_fall) : int_fall;
    assign rise_ev  = ext_mode ? (enabled && ext_rise) : int_rise;
    assign sck_oe   = !ext_mode;

    sio_clkgen #(.CODE_W(CODE_W), .BASE_EXP(BASE_EXP)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .code(ctrl_q.code),
        .fall_ev(int_fall), .rise_ev(int_rise), .sck_lvl(sck_o)
    );

    sio_ext_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i),
        .fall_ev(ext_fall), .rise_ev(ext_rise)
    );

    sio_shift_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .tx_data(tx_buf), .si(si), .so(so), .in_byte(in_byte),
        .load_tx(load_tx), .done(done), .rx_word(rx_word)
    );

    sio_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .ctrl_wr(ctrl_wr),
        .data_wr(data_wr), .data_rd(data_rd), .wdata(bus_wdata),
        .load_tx(load_tx), .done(done), .rx_word(rx_word), .busy(in_byte),
        .ctrl_q(ctrl_q), .tx_buf(tx_buf), .tx_full(tx_full), .rx_full(rx_full),
        .byte_done(byte_done), .rdata(bus_rdata)
    );
endmodule

// File: rtl/sio_checker.sv
// Temporal checks on the serial shift port, attached to every instance through bind.
// Relates the clock pin to the framing state and the buffer flags.
module sio_checker (
    input logic clk,
    input logic rst_n,
    input logic sck_o,
    input logic busy,
    input logic byte_done,
    input logic ext_mode,
    input logic tx_en,
    input logic rx_en,
    input logic tx_full,
    input logic rx_full,
    input logic data_wr
);
    // R4: the clock rests high whenever no byte is in progress
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o);

    // R5: a pending empty transmit buffer keeps the clock high on the next cycle
    assert_tx_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && tx_en && !tx_full && !busy) |=> sck_o);

    // R6: a pending full receive buffer keeps the clock high on the next cycle
    assert_rx_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && rx_en && rx_full && !busy) |=> sck_o);

    // R7: starting a byte empties the transmit buffer unless a write landed on that edge
    assert_load_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(data_wr)) |-> !tx_full);

    // R2: a low phase lasts at least two system cycles
    assert_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |=> !sck_o);

    // R8: the generated clock stays high in external-clock mode
    assert_ext_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> sck_o);

    // R9: the end-of-byte pulse is a single cycle wide
    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
endmodule

bind serial_shift_port sio_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .busy(in_byte),
    .byte_done(byte_done), .ext_mode(ext_mode), .tx_en(tx_en), .rx_en(rx_en),
    .tx_full(tx_full), .rx_full(rx_full), .data_wr(data_wr)
);

// File: tb/serial_shift_port_test.sv
// Self-checking bench: the bench acts as the serial slave or as the external master.
module serial_shift_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_o, sck_oe, so, byte_done;
    logic       sck_i = 1'b1, si = 1'b0;
    int         checks = 0, errors = 0;

    // Vector fields: select code, transmit byte, byte fed on the data-in line
    localparam logic [18:0] VECS [0:6] = '{
        {3'd0, 8'hA5, 8'h3C}, {3'd1, 8'h01, 8'h80}, {3'd2, 8'hFF, 8'h00},
        {3'd3, 8'h5A, 8'hC3}, {3'd4, 8'h80, 8'h01}, {3'd5, 8'h96, 8'h69},
        {3'd6, 8'h7E, 8'hE7}
    };

    always #5 clk = ~clk;

    serial_shift_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .so(so), .si(si),
        .byte_done(byte_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // Slave on the internal clock: drives data-in after each fall, captures data-out after each rise
    task automatic slave_byte(input logic [7:0] si_byte, output logic [7:0] so_byte,
                              output int low_len, output int start_wait, input int limit);
        int n = 0, low = 0, t = 0;
        logic prev, cur;
        bit started = 0;
        so_byte = '0; low_len = 0; start_wait = 0;
        prev = sck_o;
        while (n < 8 && t < limit) begin
            @(negedge clk); t++; cur = sck_o;
            if (prev && !cur) begin
                if (!started) begin started = 1; start_wait = t; end
                si = si_byte[n]; low = 1;
            end else if (!cur) low++;
            if (!prev && cur) begin
                so_byte[n] = so;
                if (n == 0) low_len = low;
                n++;
            end
            prev = cur;
        end
    endtask

    task automatic count_falls(input int cyc, output int f);
        logic prev;
        f = 0; prev = sck_o;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (prev && !sck_o) f++;
            prev = sck_o;
        end
    endtask

    // Master on the external clock pin with 10-cycle phases
    task automatic ext_byte(input logic [7:0] si_byte, output logic [7:0] so_byte);
        so_byte = '0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk); sck_i = 1'b0; si = si_byte[n];
            repeat (10) @(negedge clk);
            so_byte[n] = so; sck_i = 1'b1;
            repeat (10) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd, cap, cap2;
        int low, sw, sw2, f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sck idle", sck_o, 1);
        check("R1 sck driven", sck_oe, 1);
        check("R1 pulse low", byte_done, 0);
        bus_read(2'd2, rd);
        check("R1 status", rd, 8'h02);

        // Table walk: full duplex at every internal rate
        for (int i = 0; i < 7; i++) begin
            logic [2:0] code;
            code = VECS[i][18:16];
            bus_write(2'd0, 8'h18 | 8'(code));
            bus_write(2'd1, VECS[i][15:8]);
            slave_byte(VECS[i][7:0], cap, low, sw, 20000);
            check("R3 data out LSB first", cap, VECS[i][15:8]);
            check("R2 phase length", low, 1 << (code + 2));
            check("R2 pin driven", sck_oe, 1);
            check("R9 pulse high", byte_done, 1);
            @(negedge clk);
            check("R9 pulse one cycle", byte_done, 0);
            bus_read(2'd2, rd);
            check("R9 status after byte", rd, 8'h06);
            bus_read(2'd1, rd);
            check("R3 received byte", rd, VECS[i][7:0]);
        end

        // R5: transmit-only wait for a data write
        bus_write(2'd0, 8'h08);
        bus_write(2'd1, 8'h5A);
        slave_byte(8'h00, cap, low, sw, 2000);
        check("R5 first byte", cap, 8'h5A);
        count_falls(200, f);
        check("R5 clock held", f, 0);
        check("R4 clock high while waiting", sck_o, 1);
        bus_read(2'd2, rd);
        check("R5 status idle", rd, 8'h02);
        bus_write(2'd1, 8'hC3);
        slave_byte(8'h00, cap, low, sw, 2000);
        check("R5 resumed byte", cap, 8'hC3);
        check("R5 restart delay", sw <= 6, 1);

        // R6: receive-only wait for a data read
        bus_write(2'd0, 8'h10);
        slave_byte(8'h96, cap, low, sw, 2000);
        count_falls(200, f);
        check("R6 clock held", f, 0);
        bus_read(2'd2, rd);
        check("R6 status full", rd, 8'h06);
        bus_read(2'd1, rd);
        check("R6 first byte", rd, 8'h96);
        slave_byte(8'h21, cap, low, sw, 2000);
        check("R6 restart delay", sw <= 6, 1);
        bus_write(2'd0, 8'h00);
        bus_read(2'd1, rd);
        check("R6 second byte", rd, 8'h21);

        // R7: write queued during a transfer, back-to-back bytes
        bus_write(2'd0, 8'h08);
        bus_write(2'd1, 8'h11);
        fork
            begin
                slave_byte(8'h00, cap, low, sw, 2000);
                slave_byte(8'h00, cap2, low, sw2, 2000);
            end
            begin
                repeat (10) @(negedge clk);
                bus_read(2'd2, rd);
                check("R7 loaded status", rd, 8'h03);
                bus_write(2'd1, 8'hEE);
                bus_read(2'd2, rd);
                check("R7 queued status", rd, 8'h01);
            end
        join
        check("R7 first byte", cap, 8'h11);
        check("R7 second byte", cap2, 8'hEE);
        check("R7 gap one phase", sw2, 4);

        // R8: external clock mode
        bus_write(2'd0, 8'h1F);
        bus_write(2'd1, 8'h6B);
        check("R8 pin released", sck_oe, 0);
        ext_byte(8'hD2, cap);
        check("R8 data out", cap, 8'h6B);
        check("R8 generated clock quiet", sck_o, 1);
        bus_read(2'd2, rd);
        check("R8 status", rd, 8'h06);
        bus_read(2'd1, rd);
        check("R8 received byte", rd, 8'hD2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule